// File: doc/BRIEF.md
# Serial ADC Conversion Controller

This block sits on the host side of a 12-bit serial-output analog-to-digital converter. The converter is controlled by a convert-start line and read through a clock-and-data serial interface. A one-cycle start request makes the controller drive a fresh rising edge on the convert line. The controller then holds the line high for a conversion time set by a parameter, and this starts and completes the conversion. It then pulls the convert line low, which enables the converter's data output. It issues exactly twelve serial clock pulses and samples the data line on each rising edge, most significant bit first. Finally it presents the word on a parallel output together with a one-cycle valid strobe.

The controller is built around one state machine:
- IDLE: the controller waits for a request.
- ARM: the convert line is low for one cycle, so that the next step is a clean rising edge.
- CONVERT: the convert line is high and a hold timer runs.
- READ: the convert line is low and the serial clock runs.
- DONE: the valid strobe is asserted.

The transitions are:
- IDLE→ARM on start.
- ARM→CONVERT always.
- CONVERT→READ when the hold timer expires.
- READ→DONE after the high phase of the twelfth clock.
- DONE→IDLE always.

The parameter `IDLE_HIGH` selects the level of the convert line in IDLE. With it set, the line rests high between requests, so the converter sits in its low-power sleep state.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, busy, valid and sck are 0, and conv equals IDLE_HIGH.
- R2: A start sampled in IDLE makes busy 1 and conv 0 in the next cycle (ARM). From the cycle after that, conv is 1.
- R3: conv stays 1 for exactly CONV_CYCLES clock cycles and then goes to 0 for the read phase.
- R4: sck is 0 whenever the controller is not reading. In each read, exactly 12 sck pulses occur, each one SCK_HALF cycles low followed by SCK_HALF cycles high, so sck is high for 12*SCK_HALF cycles in all.
- R5: sdo is sampled on the clock edge at which sck rises. The first sampled bit lands in data[11] and the last in data[0].
- R6: valid is a single-cycle pulse, asserted in the cycle 2 + CONV_CYCLES + 24*SCK_HALF - 1 counted from the ARM cycle (index 0). busy is 1 from ARM through the valid cycle and 0 afterwards.
- R7: A start that arrives while busy is 1 is ignored. It produces no second conversion, so exactly one valid pulse occurs and busy is 0 afterwards.
- R8: With IDLE_HIGH=1, conv is 1 in IDLE, goes 0 in ARM and in READ, and returns to 1 once the controller is back in IDLE.
- R9: The word is unsigned straight binary and passes through unchanged for every code from 0x000 to 0xFFF.
- R10: data keeps the captured word after valid until the next read phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled in IDLE only |
| sdo | input | 1 | Serial data from the converter |
| busy | output | 1 | High while a conversion and read cycle is in progress |
| conv | output | 1 | Convert-start line to the converter |
| sck | output | 1 | Serial clock to the converter, idles low |
| data | output | 12 | Captured conversion word |
| valid | output | 1 | One-cycle strobe marking a new word on data |

## Verification
On every cycle, the assertions check the following:
- the valid pulse lasts one cycle;
- conv is low in the first busy cycle;
- busy cannot drop before valid;
- sck is low while idle;
- the convert-high run never exceeds the hold time;
- the bit counter stays in range.

Only the bench scenarios can show the other properties:
- the exact cycle positions of the convert edge, the valid pulse and the end of busy;
- the count of twelve clock pulses;
- bit order and word integrity across all 4096 codes, driven by a bench converter model that shifts on falling sck edges;
- that a request made while busy is dropped;
- the idle-high sleep behaviour of the second configuration.

// File: rtl/adc_conv_ctrl_pkg.sv
package adc_conv_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARM     = 3'd1,
        ST_CONVERT = 3'd2,
        ST_READ    = 3'd3,
        ST_DONE    = 3'd4
    } ctrl_state_t;
endpackage

// File: rtl/adc_hold_timer.sv
module adc_hold_timer #(
    parameter int CONV_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int TW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [TW-1:0] LOAD_VAL = TW'(CONV_CYCLES - 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= LOAD_VAL;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
    parameter int SCK_HALF = 1,
    parameter int NBITS    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic sample_tick,
    output logic last_tick
);
    localparam int DW = (2 * SCK_HALF > 1) ? $clog2(2 * SCK_HALF) : 1;
    localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [DW-1:0] HALF_M1 = DW'(SCK_HALF - 1);
    localparam logic [DW-1:0] HALF    = DW'(SCK_HALF);
    localparam logic [DW-1:0] FULL_M1 = DW'(2 * SCK_HALF - 1);
    localparam logic [BW-1:0] LAST_B  = BW'(NBITS - 1);

    logic [DW-1:0] phase;
    logic [BW-1:0] bit_idx;
    logic          wrap;

    assign wrap = (phase == FULL_M1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase   <= '0;
            bit_idx <= '0;
        end else if (wrap) begin
            phase   <= '0;
            bit_idx <= bit_idx + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign sck         = run && (phase >= HALF);
    assign sample_tick = run && (phase == HALF_M1);
    assign last_tick   = run && wrap && (bit_idx == LAST_B);

    // R4: the pulse counter never passes the last bit of the word
    a_r4_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bit_idx <= LAST_B));
endmodule

// File: rtl/adc_shift_in.sv
module adc_shift_in #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (shift_en) begin
            dout <= {dout[W-2:0], din};
        end
    end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_conv_ctrl_pkg::*;
#(
    parameter int CONV_CYCLES = 4,
    parameter int SCK_HALF    = 1,
    parameter int DATA_W      = 12,
    parameter bit IDLE_HIGH   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sdo,
    output logic              busy,
    output logic              conv,
    output logic              sck,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    localparam int CW = $clog2(CONV_CYCLES + 2);
    localparam logic [CW-1:0] HOLD_MAX = CW'(CONV_CYCLES);

    ctrl_state_t state, state_nx;
    logic timer_load, timer_done;
    logic reading, sample_tick, last_tick;

    adc_hold_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .expired(timer_done)
    );

    adc_sck_gen #(.SCK_HALF(SCK_HALF), .NBITS(DATA_W)) u_sck (
        .clk(clk), .rst_n(rst_n), .run(reading), .sck(sck),
        .sample_tick(sample_tick), .last_tick(last_tick)
    );

    adc_shift_in #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(sample_tick), .din(sdo), .dout(data)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_ARM;
            ST_ARM:     state_nx = ST_CONVERT;
            ST_CONVERT: if (timer_done) state_nx = ST_READ;
            ST_READ:    if (last_tick) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        busy       = 1'b1;
        conv       = 1'b0;
        valid      = 1'b0;
        timer_load = 1'b0;
        reading    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                conv = IDLE_HIGH;
            end
            ST_ARM:     timer_load = 1'b1;
            ST_CONVERT: conv = 1'b1;
            ST_READ:    reading = 1'b1;
            ST_DONE:    valid = 1'b1;
            default:    busy = 1'b0;
        endcase
    end

    // checker counter: length of the current convert-high run inside a busy cycle
    logic [CW-1:0] hold_run;
    always_ff @(posedge clk) begin
        if (!rst_n || !(busy && conv)) hold_run <= '0;
        else if (hold_run != '1)       hold_run <= hold_run + 1'b1;
    end

    // R3: convert line never held longer than the hold time during a cycle
    a_r3_hold_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv) |-> (hold_run < HOLD_MAX));
    // R6: valid lasts one cycle
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R2: the first busy cycle has the convert line low
    a_r2_arm_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !conv);
    // R7: busy cannot end before the result strobe, whatever start does
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !valid) |=> busy);
    // R4: serial clock idles low
    a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
endmodule

// File: tb/adc_conv_ctrl_test.sv
`timescale 1ns/1ps

module adc_model (
    input  logic        conv,
    input  logic        sck,
    input  logic [11:0] code,
    output logic        sdo
);
    logic [11:0] sh = '0;
    always @(negedge conv) sh <= code;
    always @(negedge sck)  sh <= {sh[10:0], 1'b0};
    assign sdo = sh[11];
endmodule

module adc_conv_ctrl_test;
    localparam int C0 = 4, H0 = 1;
    localparam int C1 = 3, H1 = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic start0 = 1'b0, start1 = 1'b0;
    logic [11:0] code0 = '0, code1 = '0;
    logic sdo0, sdo1, busy0, busy1, conv0, conv1, sck0, sck1, valid0, valid1;
    logic [11:0] data0, data1;

    adc_conv_ctrl #(.CONV_CYCLES(C0), .SCK_HALF(H0), .DATA_W(12), .IDLE_HIGH(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .start(start0), .sdo(sdo0), .busy(busy0),
        .conv(conv0), .sck(sck0), .data(data0), .valid(valid0)
    );
    adc_conv_ctrl #(.CONV_CYCLES(C1), .SCK_HALF(H1), .DATA_W(12), .IDLE_HIGH(1'b1)) uut_sleep (
        .clk(clk), .rst_n(rst_n), .start(start1), .sdo(sdo1), .busy(busy1),
        .conv(conv1), .sck(sck1), .data(data1), .valid(valid1)
    );
    adc_model m0 (.conv(conv0), .sck(sck0), .code(code0), .sdo(sdo0));
    adc_model m1 (.conv(conv1), .sck(sck1), .code(code1), .sdo(sdo1));

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic drive_start(input bit sel, input logic v);
        if (sel) start1 = v; else start0 = v;
    endtask

    task automatic run_one(input bit sel, input logic [11:0] v, input bit restart);
        int c, h, total, vidx, hi_cnt, sck_hi, rises, vcnt;
        bit idle_hi;
        logic pconv, psck;
        logic b, cv, s, vl;
        logic [11:0] d;
        c = sel ? C1 : C0;
        h = sel ? H1 : H0;
        idle_hi = sel;
        total = 2 + c + 24 * h;
        vidx = total - 1;
        hi_cnt = 0; sck_hi = 0; rises = 0; vcnt = 0;
        if (sel) code1 = v; else code0 = v;
        @(negedge clk);
        drive_start(sel, 1'b1);
        psck = 1'b0;
        pconv = 1'b0;
        for (int i = 0; i <= total + 2; i++) begin
            @(negedge clk);
            if (i == 0) drive_start(sel, 1'b0);
            if (restart && i == 3) drive_start(sel, 1'b1);
            if (restart && i == 4) drive_start(sel, 1'b0);
            b  = sel ? busy1 : busy0;
            cv = sel ? conv1 : conv0;
            s  = sel ? sck1 : sck0;
            vl = sel ? valid1 : valid0;
            d  = sel ? data1 : data0;
            if (i == 0) begin
                chk(b == 1'b1 && cv == 1'b0, "R2 arm busy/conv", {b, cv}, 2);
                if (sel) chk(pconv == 1'b0 && cv == 1'b0, "R8 conv low in arm", cv, 0);
            end
            if (i == 1) chk(cv == 1'b1, "R2 conv rises after arm", cv, 1);
            if (i < vidx && cv) hi_cnt++;
            if (i > 1 + c && i < vidx && sel) chk(cv == 1'b0, "R8 conv low in read", cv, 0);
            if (s) sck_hi++;
            if (s && !psck) rises++;
            if (vl) vcnt++;
            if (i == vidx) begin
                chk(vl == 1'b1, "R6 valid position", vl, 1);
                chk(d == v, "R5 R9 captured word", d, v);
                chk(b == 1'b1, "R6 busy in valid cycle", b, 1);
            end
            if (i == vidx + 1) begin
                chk(b == 1'b0, "R6 busy drops after valid", b, 0);
                chk(cv == idle_hi, "R8 idle conv level", cv, idle_hi);
            end
            if (i == total + 2) begin
                chk(d == v, "R10 data held after valid", d, v);
                if (restart) chk(b == 1'b0, "R7 no second cycle", b, 0);
            end
            psck = s;
            pconv = cv;
        end
        chk(hi_cnt == c, "R3 conv high cycles", hi_cnt, c);
        chk(rises == 12, "R4 sck rising edges", rises, 12);
        chk(sck_hi == 12 * h, "R4 sck high cycles", sck_hi, 12 * h);
        chk(vcnt == 1, restart ? "R7 single valid" : "R6 single valid", vcnt, 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy0 == 0 && valid0 == 0 && sck0 == 0 && conv0 == 0, "R1 reset idle-low",
            {busy0, valid0, sck0, conv0}, 0);
        chk(busy1 == 0 && valid1 == 0 && sck1 == 0 && conv1 == 1, "R1 reset idle-high",
            {busy1, valid1, sck1, conv1}, 1);
        for (int k = 0; k < 4096; k++) begin
            run_one(1'b0, 12'(k), (k % 97) == 5);
        end
        run_one(1'b1, 12'h000, 1'b0);
        run_one(1'b1, 12'hFFF, 1'b1);
        for (int k = 0; k < 12; k++) begin
            run_one(1'b1, 12'(1 << k), 1'b0);
            run_one(1'b1, ~12'(1 << k), k == 3);
        end
        finish_run();
    end

    initial begin
        #(5.0 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule